// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block orders two IEEE-754 values and reports the result as four condition flags (negative, zero, carry, overflow) held in a register. One input bit chooses the precision. With the bit high, both 64-bit operand buses are read as double precision. With it low, only the low 32 bits of each bus are read, as single precision. A second select replaces the second operand with the constant +0.0, so a value can be tested against zero without a register read.

A result is accepted on any cycle where the valid strobe is high. The flags change on the following clock edge and then hold until the next accepted compare. The unit also keeps a sticky invalid-operation bit. This bit is set when the exception enable is high and the first operand is a NaN, and it stays set until a clear pulse arrives. Values are ordered directly from their sign and magnitude bits. No format conversion takes place.

Top module: `fcmp_flags`

## Requirements
- R1: If either operand of an accepted compare is a NaN, the flags {N,Z,C,V} become 4'b0011. A NaN has its exponent all ones and a nonzero fraction. An infinity is not a NaN.
- R2: Equal operands give {N,Z,C,V} = 4'b0110. +0 and -0 count as equal.
- R3: If the first operand is less than the second, the flags become 4'b1000.
- R4: If the first operand is greater than the second, the flags become 4'b0010.
- R5: With op_dbl=1 the full 64 bits are compared as double precision. With op_dbl=0 only bits [31:0] are compared as single precision, and bits [63:32] have no effect.
- R6: With cmp_zero=1 the second operand is +0.0 and opnd_b has no effect.
- R7: The flags load on the clock edge that samples op_valid=1. They keep their value on every other cycle. Reset sets them to 4'b0000.
- R8: inv_sticky is set at the edge that samples op_valid=1, inv_trap_en=1 and a NaN first operand. A NaN second operand alone does not set it, and neither does inv_trap_en=0.
- R9: inv_sticky stays set until an edge samples inv_clear=1, which clears it. If a set event and a clear fall on the same edge, the set wins. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept a compare this cycle |
| op_dbl | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| cmp_zero | input | 1 | 1 = compare first operand against +0.0 |
| inv_trap_en | input | 1 | Allow a NaN first operand to set inv_sticky |
| inv_clear | input | 1 | Clear inv_sticky |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| inv_sticky | output | 1 | Sticky invalid-operation flag |

## Verification
Setting the sticky invalid bit and clearing it can land on the same edge. The bench produces this by driving an accepted compare with a NaN first operand and the enable high, while inv_clear is also high. It expects inv_sticky to read 1 afterwards, and a later clear with no set event must bring it back to 0. The same cycle also loads the unordered flags, so both results are checked together after that edge.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int DW = 64,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_dbl,
  input  logic          cmp_zero,
  input  logic          inv_trap_en,
  input  logic          inv_clear,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          inv_sticky
);
  localparam int DE = (DW == 64) ? 11 : 8;
  localparam int SE = 8;
  localparam int DF = DW - 1 - DE;
  localparam int SF = SW - 1 - SE;

  logic [DW-1:0] b_in;
  logic          a_s, b_s, a_nan, b_nan;
  logic [DW-1:0] a_m, b_m;
  logic          both_zero, eq, lt;
  logic [3:0]    nzcv_nxt, nzcv_q;

  function automatic logic is_nan(input logic [DW-1:0] x, input logic dbl);
    if (dbl) return (&x[DW-2:DF]) && (|x[DF-1:0]);
    return (&x[SW-2:SF]) && (|x[SF-1:0]);
  endfunction

  assign b_in  = cmp_zero ? '0 : opnd_b;
  assign a_s   = op_dbl ? opnd_a[DW-1] : opnd_a[SW-1];
  assign b_s   = op_dbl ? b_in[DW-1]   : b_in[SW-1];
  assign a_m   = op_dbl ? {1'b0, opnd_a[DW-2:0]} : {{(DW-SW+1){1'b0}}, opnd_a[SW-2:0]};
  assign b_m   = op_dbl ? {1'b0, b_in[DW-2:0]}   : {{(DW-SW+1){1'b0}}, b_in[SW-2:0]};
  assign a_nan = is_nan(opnd_a, op_dbl);
  assign b_nan = is_nan(b_in, op_dbl);

  assign both_zero = (a_m == '0) && (b_m == '0);
  assign eq = both_zero || ((a_s == b_s) && (a_m == b_m));
  assign lt = !eq && ((a_s && !b_s) ||
                      (!a_s && !b_s && (a_m < b_m)) ||
                      (a_s && b_s && (a_m > b_m)));

  always_comb begin
    if (a_nan || b_nan) nzcv_nxt = 4'b0011;
    else if (eq)        nzcv_nxt = 4'b0110;
    else if (lt)        nzcv_nxt = 4'b1000;
    else                nzcv_nxt = 4'b0010;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nzcv_q     <= 4'b0000;
      inv_sticky <= 1'b0;
    end else begin
      if (op_valid) nzcv_q <= nzcv_nxt;
      if (op_valid && inv_trap_en && a_nan) inv_sticky <= 1'b1;
      else if (inv_clear)                   inv_sticky <= 1'b0;
    end
  end

  assign {flag_n, flag_z, flag_c, flag_v} = nzcv_q;
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_dbl,
  input logic        cmp_zero,
  input logic        inv_trap_en,
  input logic        inv_clear,
  input logic [63:0] opnd_a,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_v,
  input logic        inv_sticky
);
  logic [3:0] f;
  logic a_nan_c, a_zero_c;
  assign f = {flag_n, flag_z, flag_c, flag_v};
  assign a_nan_c = op_dbl ? ((opnd_a[62:52] == 11'h7FF) && (opnd_a[51:0] != 0))
                          : ((opnd_a[30:23] == 8'hFF) && (opnd_a[22:0] != 0));
  assign a_zero_c = op_dbl ? (opnd_a[62:0] == 0) : (opnd_a[30:0] == 0);

  assert_flags_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (f == 4'b0000) || (f == 4'b0011) || (f == 4'b0110) || (f == 4'b1000) || (f == 4'b0010));

  assert_nan_unordered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && a_nan_c |=> f == 4'b0011);

  assert_zero_vs_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && cmp_zero && a_zero_c |=> f == 4'b0110);

  assert_hold_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(f));

  assert_inv_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && inv_trap_en && a_nan_c |=> inv_sticky);

  assert_inv_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_sticky && !(op_valid && inv_trap_en) |=> !inv_sticky);

  assert_inv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_sticky && !inv_clear |=> inv_sticky);
endmodule

bind fcmp_flags fcmp_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dbl(op_dbl),
  .cmp_zero(cmp_zero), .inv_trap_en(inv_trap_en), .inv_clear(inv_clear),
  .opnd_a(opnd_a), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
  .flag_v(flag_v), .inv_sticky(inv_sticky)
);

// File: tb/fcmp_flags_test.sv
module fcmp_flags_test;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_dbl = 0, cmp_zero = 0, inv_trap_en = 0, inv_clear = 0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic flag_n, flag_z, flag_c, flag_v, inv_sticky;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [3:0] UN = 4'b0011, EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010;

  always #5 clk = ~clk;

  fcmp_flags uut (.*);

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                     input logic z, input logic en, input logic clr);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_dbl = dbl; cmp_zero = z; inv_trap_en = en;
    inv_clear = clr; op_valid = 1;
    @(negedge clk);
    op_valid = 0; inv_clear = 0; inv_trap_en = 0;
  endtask

  function automatic logic [3:0] fl();
    return {flag_n, flag_z, flag_c, flag_v};
  endfunction

  task automatic t_reset;
    chk("R7 reset flags", fl(), 4'b0000);
    chk("R9 reset sticky", {3'b0, inv_sticky}, 4'b0000);
  endtask

  task automatic t_single;
    cmp(64'h3F800000, 64'h40000000, 0, 0, 0, 0); chk("R3 1<2", fl(), LT);
    cmp(64'h40000000, 64'h3F800000, 0, 0, 0, 0); chk("R4 2>1", fl(), GT);
    cmp(64'hBF800000, 64'h3F800000, 0, 0, 0, 0); chk("R3 -1<1", fl(), LT);
    cmp(64'hBF800000, 64'hC0000000, 0, 0, 0, 0); chk("R4 -1>-2", fl(), GT);
    cmp(64'h3F800000, 64'h3F800000, 0, 0, 0, 0); chk("R2 1==1", fl(), EQ);
    cmp(64'h80000000, 64'h00000000, 0, 0, 0, 0); chk("R2 -0==+0", fl(), EQ);
    cmp(64'h7FC00000, 64'h3F800000, 0, 0, 0, 0); chk("R1 a NaN", fl(), UN);
    cmp(64'h3F800000, 64'hFF800001, 0, 0, 0, 0); chk("R1 b NaN", fl(), UN);
    cmp(64'h7F800000, 64'h3F800000, 0, 0, 0, 0); chk("R1 inf not NaN", fl(), GT);
  endtask

  task automatic t_precision;
    cmp({32'hFFF80000, 32'h3F800000}, {32'h0, 32'h40000000}, 0, 0, 0, 0);
    chk("R5 single ignores high bits", fl(), LT);
    cmp(64'h3FF0000000000000, 64'h4000000000000000, 1, 0, 0, 0);
    chk("R5 double 1<2", fl(), LT);
    cmp(64'hC000000000000000, 64'h0000000000000001, 1, 0, 0, 0);
    chk("R5 double -2<tiny", fl(), LT);
    cmp(64'h7FF8000000000000, 64'h0, 1, 0, 0, 0);
    chk("R1 double NaN", fl(), UN);
    cmp(64'h3FF0000000000000, 64'h4000000000000000, 0, 0, 0, 0);
    chk("R5 same bits as single equal", fl(), EQ);
  endtask

  task automatic t_zero;
    cmp(64'h3F800000, 64'h7FC00000, 0, 1, 0, 0); chk("R6 1>0 b ignored", fl(), GT);
    cmp(64'h80000000, 64'hBF800000, 0, 1, 0, 0); chk("R6 -0==0", fl(), EQ);
    cmp(64'hBFF0000000000000, 64'hBFF0000000000000, 1, 1, 0, 0); chk("R6 -1<0", fl(), LT);
  endtask

  task automatic t_hold;
    cmp(64'h3F800000, 64'h40000000, 0, 0, 0, 0);
    @(negedge clk); opnd_a = 64'h7FC00000; opnd_b = 64'h0;
    @(negedge clk); @(negedge clk);
    chk("R7 hold without valid", fl(), LT);
  endtask

  task automatic t_sticky;
    cmp(64'h3F800000, 64'h7FC00000, 0, 0, 1, 0); chk("R8 b NaN no set", {3'b0, inv_sticky}, 0);
    cmp(64'h7FC00000, 64'h0, 0, 0, 0, 0);        chk("R8 enable low no set", {3'b0, inv_sticky}, 0);
    cmp(64'h7FC00000, 64'h0, 0, 0, 1, 0);        chk("R8 a NaN sets", {3'b0, inv_sticky}, 1);
    cmp(64'h3F800000, 64'h3F800000, 0, 0, 1, 0); chk("R9 stays set", {3'b0, inv_sticky}, 1);
    @(negedge clk); inv_clear = 1; @(negedge clk); inv_clear = 0;
    chk("R9 clear", {3'b0, inv_sticky}, 0);
    cmp(64'h7FF0000000000001, 64'h0, 1, 0, 1, 1);
    chk("R9 set beats clear", {3'b0, inv_sticky}, 1);
    chk("R1 same edge flags", fl(), UN);
    @(negedge clk); inv_clear = 1; @(negedge clk); inv_clear = 0;
    chk("R9 clear after", {3'b0, inv_sticky}, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_precision();
    t_zero();
    t_hold();
    t_sticky();
    finish_run();
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule